// File: doc/BRIEF.md
# Prescaled 64-bit Event Timer

This block keeps a free-running 64-bit up-counter that advances once every (divider + 1) clocks. Software reaches it through a word-addressed 32-bit register port. The counter can be read and written in two 32-bit halves. A 64-bit comparator raises a sticky event flag whenever comparison is enabled and the count has reached or passed the compare value. The flag can drive a level interrupt.

When the reload option is on, each match adds a programmed 32-bit step to the comparator, so events recur at a fixed spacing without software intervention. Software can stop the counter, load a new count, and rearm the comparator. While comparison is disabled, a half-written comparator can never produce an event.

Register reads return data combinationally from the addressed register. Writes take effect on the clock edge where `sel` and `we` are both high.

Top module: `gtimer_cmp`

## Requirements
- R1: After reset, every register (count 0x00/0x04, control 0x08, status 0x0C, compare 0x10/0x14, step 0x18) reads zero and `irq` is low.
- R2: With control bit 0 (run) set, the count rises by one on every (D+1)-th clock edge, where D is control bits 11:8. Over N clocks from the edge that sets run, the count therefore gains floor(N/(D+1)).
- R3: With run clear, the count holds its value. Writes to 0x00 load bits 31:0 and writes to 0x04 load bits 63:32, and these writes are read back unchanged.
- R4: When the low word wraps from 0xFFFFFFFF, the high word gains one on that same counting edge.
- R5: Status bit 0 (event flag) sets one edge after compare-enable (control bit 1) is seen together with count >= compare. This includes a compare value already below the count.
- R6: The flag is sticky. Writing 1 to status bit 0 clears it, and writing 0 leaves it set.
- R7: If a match and a write-1-to-clear fall on the same edge, the flag stays set.
- R8: With reload (control bit 3) set, each edge that sees a match adds the step register (0x18) to the comparator.
- R9: `irq` equals the flag ANDed with control bit 2 and stays high until the flag is cleared or bit 2 is cleared.
- R10: While compare-enable is clear, writes to either compare half never set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Register access select |
| we | input | 1 | Write strobe (with sel) |
| addr | input | 5 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the addressed register |
| irq | output | 1 | Level interrupt request |

## Verification
The counting path is exercised with a table of divider settings: no division, a maximum division of 16, and odd and even ratios. The run lengths are chosen so that a divider that is off by one clock changes the final count. The comparator is checked in several cases: a compare value already behind the count, which separates a greater-or-equal compare from an equality compare; a far-future compare written while disabled; and a clear that collides with a live match. Periodic reload is run across two matches. The final compare value shows whether exactly one step is added per match.

// File: rtl/gtimer_cmp.sv
module gtimer_cmp #(
  parameter int AW   = 5,
  parameter int PS_W = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  output logic          irq
);
  localparam logic [AW-1:0] A_CLO = 'h00, A_CHI = 'h04, A_CTL = 'h08,
                            A_STA = 'h0C, A_KLO = 'h10, A_KHI = 'h14,
                            A_STP = 'h18;

  logic [63:0]     cnt, cmp;
  logic [31:0]     step;
  logic [PS_W-1:0] div, pdiv;
  logic            run, cmp_en, irq_en, auto_en, flag;

  wire wr   = sel & we;
  wire tick = run & (pdiv == div);
  wire hit  = cmp_en & (cnt >= cmp);
  wire wr_k = wr & ((addr == A_KLO) | (addr == A_KHI));

  always_ff @(posedge clk) begin
    if (!rst_n)             pdiv <= '0;
    else if (!run || tick)  pdiv <= '0;
    else                    pdiv <= pdiv + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          cnt <= '0;
    else if (wr && addr == A_CLO)        cnt[31:0]  <= wdata;
    else if (wr && addr == A_CHI)        cnt[63:32] <= wdata;
    else if (tick)                       cnt <= cnt + 64'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                     cmp <= '0;
    else if (wr && addr == A_KLO)   cmp[31:0]  <= wdata;
    else if (wr && addr == A_KHI)   cmp[63:32] <= wdata;
    else if (hit && auto_en)        cmp <= cmp + {32'd0, step};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0; cmp_en <= 1'b0; irq_en <= 1'b0; auto_en <= 1'b0;
      div <= '0; step <= '0;
    end else if (wr) begin
      if (addr == A_CTL) begin
        run     <= wdata[0];
        cmp_en  <= wdata[1];
        irq_en  <= wdata[2];
        auto_en <= wdata[3];
        div     <= wdata[8 +: PS_W];
      end
      if (addr == A_STP) step <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          flag <= 1'b0;
    else if (hit)                        flag <= 1'b1;
    else if (wr && addr == A_STA && wdata[0]) flag <= 1'b0;
  end

  assign irq = flag & irq_en;

  always_comb begin
    case (addr)
      A_CLO:   rdata = cnt[31:0];
      A_CHI:   rdata = cnt[63:32];
      A_CTL:   rdata = {{(24-PS_W){1'b0}}, div, 4'd0, auto_en, irq_en, cmp_en, run};
      A_STA:   rdata = {31'd0, flag};
      A_KLO:   rdata = cmp[31:0];
      A_KHI:   rdata = cmp[63:32];
      A_STP:   rdata = step;
      default: rdata = '0;
    endcase
  end

  wire unused_ok = wr_k;
endmodule

// File: rtl/gtimer_cmp_chk.sv
module gtimer_cmp_chk #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sel,
  input logic          we,
  input logic [AW-1:0] addr,
  input logic [63:0]   cnt,
  input logic [63:0]   cmp,
  input logic [31:0]   step,
  input logic          run,
  input logic          cmp_en,
  input logic          auto_en,
  input logic          flag,
  input logic          irq
);
  wire wr_cnt = sel & we & ((addr == 'h00) | (addr == 'h04));
  wire wr_cmp = sel & we & ((addr == 'h10) | (addr == 'h14));
  wire wr_clr = sel & we & (addr == 'h0C);

  // R3
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_cnt) |=> $stable(cnt));

  // R2
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cnt |=> (cnt == $past(cnt) || cnt == $past(cnt) + 64'd1));

  // R10
  flag_needs_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_en |=> !$rose(flag));

  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !wr_clr) |=> flag);

  // R8
  reload_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_en && auto_en && cnt >= cmp && !wr_cmp) |=>
      cmp == $past(cmp) + {32'd0, $past(step)});

  // R9
  irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag);
endmodule

bind gtimer_cmp gtimer_cmp_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .we(we), .addr(addr),
  .cnt(cnt), .cmp(cmp), .step(step), .run(run), .cmp_en(cmp_en),
  .auto_en(auto_en), .flag(flag), .irq(irq)
);

// File: tb/sim_gtimer_cmp.sv
`timescale 1ns/1ps
module sim_gtimer_cmp;
  logic clk = 1'b0, rst_n = 1'b0, sel = 1'b0, we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  gtimer_cmp u0 (.clk(clk), .rst_n(rst_n), .sel(sel), .we(we), .addr(addr),
                 .wdata(wdata), .rdata(rdata), .irq(irq));

  localparam int VEC [6][3] = '{'{0, 10, 10}, '{1, 10, 5}, '{3, 12, 3},
                                '{15, 32, 2}, '{2, 7, 2}, '{4, 4, 0}};

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  logic [31:0] v;

  initial begin
    #(5.0 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a <= 'h18; a += 4) begin rd(a[4:0], v); chk("R1", v, 32'd0); end
    chk("R1 irq", {31'd0, irq}, 32'd0);

    // R2 divider table
    for (int i = 0; i < 6; i++) begin
      wr('h00, 0); wr('h04, 0);
      wr('h08, (VEC[i][0] << 8) | 1);
      repeat (VEC[i][1] - 1) @(negedge clk);
      wr('h08, 0);
      rd('h00, v); chk("R2", v, VEC[i][2]);
    end

    // R3 load halves while stopped
    wr('h00, 32'h0000_1234); wr('h04, 32'hABCD_0000);
    repeat (5) @(negedge clk);
    rd('h00, v); chk("R3 lo", v, 32'h0000_1234);
    rd('h04, v); chk("R3 hi", v, 32'hABCD_0000);

    // R4 carry
    wr('h00, 32'hFFFF_FFFF); wr('h04, 32'd5);
    wr('h08, 1); wr('h08, 0);
    rd('h00, v); chk("R4 lo", v, 32'd0);
    rd('h04, v); chk("R4 hi", v, 32'd6);

    // R10 compare writes while disabled
    wr('h00, 100); wr('h04, 0);
    wr('h10, 0); wr('h14, 0); wr('h10, 50);
    @(negedge clk);
    rd('h0C, v); chk("R10", v, 32'd0);
    wr('h14, 32'h0000_FFFF); wr('h08, 2);
    repeat (2) @(negedge clk);
    rd('h0C, v); chk("R10 future cmp", v, 32'd0);
    wr('h08, 0);

    // R5 / R9 compare already behind count
    wr('h14, 0);
    wr('h08, 32'h6);
    @(negedge clk);
    rd('h0C, v); chk("R5", v, 32'd1);
    chk("R9 irq on", {31'd0, irq}, 32'd1);
    wr('h08, 32'h2);
    chk("R9 irq masked", {31'd0, irq}, 32'd0);

    // R7 clear colliding with live match
    wr('h0C, 1);
    rd('h0C, v); chk("R7", v, 32'd1);

    // R6 sticky and write-1-to-clear
    wr('h08, 0);
    wr('h0C, 0);
    rd('h0C, v); chk("R6 write0", v, 32'd1);
    wr('h0C, 1);
    rd('h0C, v); chk("R6 clear", v, 32'd0);

    // R8 periodic reload
    wr('h00, 0); wr('h04, 0); wr('h10, 10); wr('h14, 0); wr('h18, 10);
    wr('h08, 32'hB);
    repeat (24) @(negedge clk);
    wr('h08, 0);
    rd('h10, v); chk("R8 cmp", v, 32'd30);
    rd('h00, v); chk("R8 cnt", v, 32'd25);
    rd('h0C, v); chk("R8 flag", v, 32'd1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule